// File: doc/BRIEF.md
# Unbundled Branch Sequencing Unit

This unit is the branch front end of a statically scheduled wide-issue core. A branch arrives as three separately scheduled operations. A prepare operation writes a target address into one of a small set of target registers and starts a speculative instruction fetch from that address. A compare operation writes a one-bit predicate. If that compare also names a target register whose fetch is still outstanding, it settles that fetch. A false result cancels the fetch. A true result raises a demand fetch.

A branch operation names a target register and a predicate register. It redirects the program counter only when the predicate is true. Several branch slots can issue in the same cycle, and the lowest taken slot wins. If a taken branch reaches its target before that target's fetch has been acknowledged, the program counter still moves to the target, and a stall flag holds the front end until the acknowledgement arrives.

Every output is registered. A result appears on the ports one clock edge after the operation that causes it.

Top module: `brseq`

## Requirements
- R1: After reset, next_pc equals RESET_PC (0 by default), fq_req, fq_cancel, fetch_stall and br_err are all 0, and every target register is invalid.
- R2: A prepare operation gives fq_req=1, fq_spec=1, fq_addr equal to the prepared target and fq_tr equal to the register number on the next edge. It does not redirect next_pc, which advances by BUNDLE.
- R3: A compare operation writes predicate register cmp_pr and never changes next_pc.
- R4: A compare with result 0 that names a register whose fetch is outstanding sets that register's bit in fq_cancel (bit i for register i) on the next edge, and it clears the outstanding state.
- R5: A compare with result 1 that names a register whose fetch is outstanding issues fq_req with fq_spec=0 and fq_addr set to the stored target.
- R6: When a prepare and a promoting compare arrive in the same cycle, the request port carries the prepare.
- R7: A branch whose predicate register holds 1 and whose target register is valid sets next_pc to the stored target on the next edge. The branch reads the predicate value from before any compare in the same cycle.
- R8: A cycle with no taken branch and no stall advances next_pc by BUNDLE (16 by default).
- R9: A branch with a true predicate that names an invalid target register pulses br_err for one cycle and falls through.
- R10: When several branch slots are taken in one cycle, the lowest-numbered slot picks the target.
- R11: A taken branch whose target fetch is still outstanding raises fetch_stall from the next edge. The stall holds next_pc and clears on the edge after fq_ack names that register.
- R12: A prepare to a register whose fetch is outstanding sets that register's fq_cancel bit and issues a new speculative request.
- R13: fq_ack clears a register's outstanding state, so a later false compare on that register cancels nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| prep_valid | input | 1 | Prepare operation issued |
| prep_tr | input | TW | Target register written by the prepare |
| prep_target | input | PC_W | Target address |
| cmp_valid | input | 1 | Compare operation issued |
| cmp_pr | input | PW | Predicate register written |
| cmp_tr | input | TW | Target register whose fetch the compare settles |
| cmp_result | input | 1 | Predicate value |
| br_valid | input | SLOTS | Branch issued, one bit per slot |
| br_tr | input | SLOTS*TW | Target register per slot |
| br_pr | input | SLOTS*PW | Guarding predicate register per slot |
| fq_ack | input | 1 | Fetch port has completed a request |
| fq_ack_tr | input | TW | Register whose fetch completed |
| fq_req | output | 1 | Fetch request valid |
| fq_spec | output | 1 | 1 for speculative, 0 for demand |
| fq_addr | output | PC_W | Fetch address |
| fq_tr | output | TW | Register the request belongs to |
| fq_cancel | output | NTR | Cancel mask, one bit per register |
| next_pc | output | PC_W | Next bundle address |
| fetch_stall | output | 1 | Waiting for the fetch of a taken target |
| br_err | output | 1 | Branch named an invalid target register |

## Verification
Every result in this unit is due exactly one clock edge after the operation that causes it. This holds for requests, cancels, the program-counter update, br_err and the rise of fetch_stall. The only exception is the stall release, which follows one edge after the matching acknowledgement. The bench drives each operation just after a rising edge and reads the outputs just after the next one. Fall-through checks compare next_pc with the value read before that edge plus one bundle.

// File: rtl/brseq.sv
module brseq #(
  parameter int PC_W = 32,
  parameter int NTR = 4,
  parameter int NPR = 8,
  parameter int SLOTS = 2,
  parameter int BUNDLE = 16,
  parameter logic [PC_W-1:0] RESET_PC = '0,
  localparam int TW = $clog2(NTR),
  localparam int PW = $clog2(NPR)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  prep_valid,
  input  logic [TW-1:0]         prep_tr,
  input  logic [PC_W-1:0]       prep_target,
  input  logic                  cmp_valid,
  input  logic [PW-1:0]         cmp_pr,
  input  logic [TW-1:0]         cmp_tr,
  input  logic                  cmp_result,
  input  logic [SLOTS-1:0]      br_valid,
  input  logic [SLOTS*TW-1:0]   br_tr,
  input  logic [SLOTS*PW-1:0]   br_pr,
  input  logic                  fq_ack,
  input  logic [TW-1:0]         fq_ack_tr,
  output logic                  fq_req,
  output logic                  fq_spec,
  output logic [PC_W-1:0]       fq_addr,
  output logic [TW-1:0]         fq_tr,
  output logic [NTR-1:0]        fq_cancel,
  output logic [PC_W-1:0]       next_pc,
  output logic                  fetch_stall,
  output logic                  br_err
);
  logic [PC_W-1:0] tgt [NTR];
  logic [NTR-1:0]  vld, pend;
  logic [NPR-1:0]  pred;
  logic [TW-1:0]   stall_tr, win_tr;
  logic            win;

  always_comb begin
    win = 1'b0;
    win_tr = '0;
    for (int s = SLOTS-1; s >= 0; s--)
      if (br_valid[s] && pred[br_pr[s*PW +: PW]]) begin
        win = 1'b1;
        win_tr = br_tr[s*TW +: TW];
      end
  end

  wire take    = win && vld[win_tr];
  wire bad     = win && !vld[win_tr];
  wire cmp_hit = cmp_valid && vld[cmp_tr] && pend[cmp_tr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NTR; i++) tgt[i] <= '0;
      vld <= '0;
      pend <= '0;
      pred <= '0;
      stall_tr <= '0;
      fq_req <= 1'b0;
      fq_spec <= 1'b0;
      fq_addr <= '0;
      fq_tr <= '0;
      fq_cancel <= '0;
      next_pc <= RESET_PC;
      fetch_stall <= 1'b0;
      br_err <= 1'b0;
    end else begin
      fq_req <= 1'b0;
      fq_cancel <= '0;
      br_err <= bad;
      if (fq_ack) pend[fq_ack_tr] <= 1'b0;
      if (cmp_valid) pred[cmp_pr] <= cmp_result;
      if (cmp_hit) begin
        if (!cmp_result) begin
          fq_cancel[cmp_tr] <= 1'b1;
          pend[cmp_tr] <= 1'b0;
        end else if (!prep_valid) begin
          fq_req <= 1'b1;
          fq_spec <= 1'b0;
          fq_addr <= tgt[cmp_tr];
          fq_tr <= cmp_tr;
        end
      end
      if (prep_valid) begin
        if (pend[prep_tr] && !(fq_ack && fq_ack_tr == prep_tr))
          fq_cancel[prep_tr] <= 1'b1;
        tgt[prep_tr] <= prep_target;
        vld[prep_tr] <= 1'b1;
        pend[prep_tr] <= 1'b1;
        fq_req <= 1'b1;
        fq_spec <= 1'b1;
        fq_addr <= prep_target;
        fq_tr <= prep_tr;
      end
      if (take) next_pc <= tgt[win_tr];
      else if (!fetch_stall) next_pc <= next_pc + PC_W'(BUNDLE);
      if (take) begin
        fetch_stall <= pend[win_tr] && !(fq_ack && fq_ack_tr == win_tr);
        stall_tr <= win_tr;
      end else if (fetch_stall && fq_ack && fq_ack_tr == stall_tr) begin
        fetch_stall <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/brseq_chk.sv
module brseq_chk #(
  parameter int PC_W = 32,
  parameter int NTR = 4,
  parameter int SLOTS = 2,
  parameter int BUNDLE = 16,
  localparam int TW = $clog2(NTR)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             prep_valid,
  input logic [TW-1:0]    prep_tr,
  input logic [PC_W-1:0]  prep_target,
  input logic             cmp_valid,
  input logic [TW-1:0]    cmp_tr,
  input logic             cmp_result,
  input logic [SLOTS-1:0] br_valid,
  input logic             fq_ack,
  input logic             fq_req,
  input logic             fq_spec,
  input logic [PC_W-1:0]  fq_addr,
  input logic [NTR-1:0]   fq_cancel,
  input logic [PC_W-1:0]  next_pc,
  input logic             fetch_stall,
  input logic [NTR-1:0]   pend
);
  p_prep_spec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    prep_valid |=> fq_req && fq_spec && fq_addr == $past(prep_target));

  p_false_cancel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && !cmp_result && pend[cmp_tr] |=> fq_cancel[$past(cmp_tr)]);

  p_true_demand_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && cmp_result && pend[cmp_tr] && !prep_valid |=> fq_req && !fq_spec);

  p_fall_through_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_stall && br_valid == '0 |=> next_pc == $past(next_pc) + PC_W'(BUNDLE));

  p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stall && br_valid == '0 |=> next_pc == $past(next_pc));

  p_reprep_cancel_r12: assert property (@(posedge clk) disable iff (!rst_n)
    prep_valid && pend[prep_tr] && !fq_ack |=> fq_cancel[$past(prep_tr)]);
endmodule

bind brseq brseq_chk #(.PC_W(PC_W), .NTR(NTR), .SLOTS(SLOTS), .BUNDLE(BUNDLE)) u_chk (.*);

// File: tb/tb_brseq.sv
module tb_brseq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic prep_valid, cmp_valid, cmp_result, fq_ack;
  logic [1:0] prep_tr, cmp_tr, fq_ack_tr;
  logic [31:0] prep_target;
  logic [2:0] cmp_pr;
  logic [1:0] br_valid;
  logic [3:0] br_tr;
  logic [5:0] br_pr;
  logic fq_req, fq_spec, fetch_stall, br_err;
  logic [31:0] fq_addr, next_pc;
  logic [1:0] fq_tr;
  logic [3:0] fq_cancel;
  int checks = 0, errors = 0;
  logic [31:0] pc0;

  always #5 clk = ~clk;

  brseq dut (.*);

  // row: [23:22] target reg, [21:19] predicate reg, [18] predicate value, [15:0] target
  localparam logic [23:0] TBL [6] = '{
    {2'd1, 3'd2, 1'b1, 2'b0, 16'h4000},
    {2'd2, 3'd3, 1'b0, 2'b0, 16'h5000},
    {2'd3, 3'd6, 1'b1, 2'b0, 16'h6040},
    {2'd0, 3'd1, 1'b0, 2'b0, 16'h7000},
    {2'd0, 3'd5, 1'b1, 2'b0, 16'h0880},
    {2'd3, 3'd0, 1'b0, 2'b0, 16'hfff0}
  };

  task automatic clr();
    prep_valid = 0; prep_tr = 0; prep_target = 0;
    cmp_valid = 0; cmp_pr = 0; cmp_tr = 0; cmp_result = 0;
    br_valid = 0; br_tr = 0; br_pr = 0; fq_ack = 0; fq_ack_tr = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    clr();
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic prep(input logic [1:0] r, input logic [31:0] t);
    prep_valid = 1; prep_tr = r; prep_target = t;
  endtask

  task automatic cmp(input logic [2:0] p, input logic [1:0] r, input logic v);
    cmp_valid = 1; cmp_pr = p; cmp_tr = r; cmp_result = v;
  endtask

  task automatic ack(input logic [1:0] r);
    fq_ack = 1; fq_ack_tr = r;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clr();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk(next_pc == 0, "R1 pc", next_pc, 0);
    chk({fq_req, fq_cancel, fetch_stall, br_err} == 0, "R1 flags",
        {fq_req, fq_cancel, fetch_stall, br_err}, 0);

    // R3 compare only; R1 tr0 invalid -> R9 error
    cmp(0, 0, 1); pc0 = next_pc; tick();
    chk(next_pc == pc0 + 16, "R3", next_pc, pc0 + 16);
    br_valid = 2'b01; br_tr = 4'd0; br_pr = 6'd0; pc0 = next_pc; tick();
    chk(br_err == 1, "R9 err", br_err, 1);
    chk(next_pc == pc0 + 16, "R9 fall", next_pc, pc0 + 16);
    tick();
    chk(br_err == 0, "R9 pulse", br_err, 0);

    // R2
    prep(1, 32'h1000); pc0 = next_pc; tick();
    chk(fq_req && fq_spec && fq_addr == 32'h1000 && fq_tr == 1, "R2 req", fq_addr, 32'h1000);
    chk(next_pc == pc0 + 16, "R2 nopc", next_pc, pc0 + 16);

    // R5
    cmp(1, 1, 1); tick();
    chk(fq_req && !fq_spec && fq_addr == 32'h1000, "R5", {fq_req, fq_spec}, 2'b10);

    // R13
    ack(1); tick();
    cmp(2, 1, 0); tick();
    chk(fq_cancel == 0 && !fq_req, "R13", fq_cancel, 0);

    // R4
    prep(2, 32'h2000); tick();
    cmp(3, 2, 0); tick();
    chk(fq_cancel == 4'b0100, "R4 cancel", fq_cancel, 4'b0100);
    chk(!fq_req, "R4 noreq", fq_req, 0);

    // R6
    prep(0, 32'h0400); tick();
    prep(3, 32'h3000); cmp(4, 0, 1); tick();
    chk(fq_req && fq_spec && fq_addr == 32'h3000 && fq_tr == 3, "R6", fq_addr, 32'h3000);
    ack(0); tick();
    ack(3); tick();

    // R12
    prep(2, 32'h2400); tick();
    prep(2, 32'h2800); tick();
    chk(fq_cancel == 4'b0100, "R12 cancel", fq_cancel, 4'b0100);
    chk(fq_req && fq_spec && fq_addr == 32'h2800, "R12 req", fq_addr, 32'h2800);
    ack(2); tick();

    // R10
    cmp(4, 0, 1); tick();
    cmp(5, 0, 1); tick();
    cmp(6, 0, 0); tick();
    br_valid = 2'b11; br_tr = {2'd3, 2'd1}; br_pr = {3'd5, 3'd4}; tick();
    chk(next_pc == 32'h1000, "R10 low", next_pc, 32'h1000);
    br_valid = 2'b11; br_tr = {2'd3, 2'd1}; br_pr = {3'd5, 3'd6}; tick();
    chk(next_pc == 32'h3000, "R10 skip", next_pc, 32'h3000);

    // R7 predicate read before same-cycle compare
    cmp(6, 0, 1); br_valid = 2'b01; br_tr = 4'd1; br_pr = 6'd6; pc0 = next_pc; tick();
    chk(next_pc == pc0 + 16, "R7 old pred", next_pc, pc0 + 16);

    // R11
    prep(0, 32'h0500); tick();
    cmp(7, 0, 1); tick();
    br_valid = 2'b01; br_tr = 4'd0; br_pr = 6'd7; tick();
    chk(next_pc == 32'h0500, "R11 pc", next_pc, 32'h0500);
    chk(fetch_stall == 1, "R11 stall", fetch_stall, 1);
    tick();
    chk(fetch_stall == 1 && next_pc == 32'h0500, "R11 hold", next_pc, 32'h0500);
    ack(0); tick();
    chk(fetch_stall == 0 && next_pc == 32'h0500, "R11 release", fetch_stall, 0);
    tick();
    chk(next_pc == 32'h0510, "R11 resume", next_pc, 32'h0510);

    // R7 / R8 table
    for (int i = 0; i < 6; i++) begin
      logic [31:0] t;
      t = {16'h0, TBL[i][15:0]};
      prep(TBL[i][23:22], t); tick();
      ack(TBL[i][23:22]); tick();
      cmp(TBL[i][21:19], TBL[i][23:22], TBL[i][18]); tick();
      br_valid = 2'b01; br_tr = {2'd0, TBL[i][23:22]}; br_pr = {3'd0, TBL[i][21:19]};
      pc0 = next_pc; tick();
      if (TBL[i][18]) chk(next_pc == t, "R7 table", next_pc, t);
      else chk(next_pc == pc0 + 16, "R8 table", next_pc, pc0 + 16);
      chk(fetch_stall == 0, "R11 no stall after ack", fetch_stall, 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule